// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM. Each word is 36 bits wide and is split into four 9-bit byte lanes. Address and control are registered on one rising clock edge. The data cycle for that operation is the second clock after it, whether the operation reads or writes. Write data therefore lags its address by the same two cycles as read data. A controller can issue reads and writes in any mix on consecutive cycles, and the shared bus never needs an idle turnaround cycle.

The bidirectional bus is split into three ports: `din_i` for write data, `dout_o` for read data, and `dout_en_o` to tell when the block drives the bus. An active-low clock enable freezes the whole pipeline. Three chip enables gate the start of new operations. An internal 2-bit burst counter supplies three further addresses after a load, in either linear or interleaved order. The output enable is asynchronous and removes the drive at once. The memory depth is a parameter.

Top module: `zbt_sram`

## Requirements
- R1: Clock edges count only when `clk_en_ni` is low. An operation is sampled at edge t, with `rw_i`=1 for a read and 0 for a write. For a read, `dout_o` carries its word and `dout_en_o` is high in the cycle after edge t+1. For a write, `din_i` is captured at edge t+2.
- R2: Reads and writes can be issued on every enabled edge in any order. Every read returns the most recent data written to its address, with no idle cycle between operations.
- R3: While `clk_en_ni` is high, every input except `oe_ni` is ignored. The memory, pipeline and burst state do not change, and neither do `dout_o` and `dout_en_o`.
- R4: The block counts as selected when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A load (`adv_ld_ni`=0) while selected starts a new operation. A load while not selected starts nothing and ends any burst. After that, advances start nothing until the next selected load.
- R5: Operations already issued still complete normally after a deselect.
- R6: `dout_en_o` is low in the data cycle of a write, of a deselect and of an idle advance.
- R7: `oe_ni` high forces `dout_en_o` low without waiting for a clock edge, whatever the pipeline holds.
- R8: A low `bw_ni[k]` at issue enables lane k of the write, which is word bits 9k+8 down to 9k. Lanes whose bit is high keep their old contents.
- R9: An advance (`adv_ld_ni`=1) during a burst issues the next burst address. It keeps the read or write direction of the load and ignores `rw_i` and `addr_i`. It takes its lane mask from `bw_ni` in the advancing cycle.
- R10: The n-th advance after a load replaces the two low address bits. With `lin_burst_i`=1 they become (base + n) mod 4. With `lin_burst_i`=0 they become base XOR (n mod 4). The upper address bits stay fixed, and the sequence wraps after four words.
- R11: A read issued one edge after a write to the same address returns the old word merged with the write data in the lanes that write enabled.
- R12: After reset the pipeline is empty, no burst is active and `dout_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high stalls |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_ld_ni | input | 1 | 0 loads a new address, 1 advances the burst |
| rw_i | input | 1 | 1 read, 0 write |
| bw_ni | input | 4 | Per-lane write enables, active low |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| lin_burst_i | input | 1 | 1 linear burst order, 0 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| din_i | input | 36 | Write data |
| dout_o | output | 36 | Read data |
| dout_en_o | output | 1 | Block drives the bus |

## Verification
Strictly alternating write/read streams show that direction changes cost no cycle and that write data is bound to the address issued two edges earlier. A write followed at once by a read of the same address, with full and partial masks, separates the pending-write merge from a stale array read. Bursts are loaded with misaligned base addresses in both orders and run past four words with `rw_i` toggled. This distinguishes linear from interleaved sequencing, wraparound and direction retention. Stalls placed inside write and read pipelines, deselects through each chip enable in turn, and a long random mix over a few addresses show that frozen state, dropped bursts and in-flight completion interact correctly.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  // overlay enabled lanes of new_w onto old_w
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_mask_t m);
    word_t r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (m[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/zbt_array.sv
module zbt_array import zbt_pkg::*; #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       we_i,
  input  lane_mask_t be_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t      wdata_i,
  input  logic [AW-1:0] raddr_i,
  output word_t      rdata_o
);
  word_t mem [DEPTH];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[k]) mem[waddr_i][k*LANE_W +: LANE_W] <= wdata_i[k*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen import zbt_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ld_ni,
  input  logic          sel_i,
  input  logic          rd_i,
  input  lane_mask_t    be_i,
  input  logic [AW-1:0] addr_i,
  input  logic          lin_i,
  output logic          vld_o,
  output logic          rd_o,
  output lane_mask_t    be_o,
  output logic [AW-1:0] addr_o
);
  logic          active_q, dir_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nx, lo_nx;

  assign cnt_nx = cnt_q + 2'd1;
  assign lo_nx  = lin_i ? (base_q[1:0] + cnt_nx) : (base_q[1:0] ^ cnt_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      vld_o    <= 1'b0;
      rd_o     <= 1'b0;
      be_o     <= '0;
      addr_o   <= '0;
    end else if (en_i) begin
      if (!ld_ni) begin
        active_q <= sel_i;
        vld_o    <= sel_i;
        if (sel_i) begin
          base_q <= addr_i;
          cnt_q  <= '0;
          dir_q  <= rd_i;
          rd_o   <= rd_i;
          be_o   <= be_i;
          addr_o <= addr_i;
        end
      end else if (active_q) begin
        cnt_q  <= cnt_nx;
        vld_o  <= 1'b1;
        rd_o   <= dir_q;
        be_o   <= be_i;
        addr_o <= {base_q[AW-1:2], lo_nx};
      end else begin
        vld_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram import zbt_pkg::*; #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              adv_ld_ni,
  input  logic              rw_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              lin_burst_i,
  input  logic              oe_ni,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic          en, sel;
  logic          s1_vld, s1_rd, s2_vld, s2_rd;
  lane_mask_t    s1_be, s2_be;
  logic [AW-1:0] s1_addr, s2_addr;
  word_t         arr_rdata, rd_word, dout_q;
  logic          dout_en_q, wr_hit;

  assign en  = ~clk_en_ni;
  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  zbt_burst_gen #(.AW(AW)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .ld_ni  (adv_ld_ni),
    .sel_i  (sel),
    .rd_i   (rw_i),
    .be_i   (~bw_ni),
    .addr_i (addr_i),
    .lin_i  (lin_burst_i),
    .vld_o  (s1_vld),
    .rd_o   (s1_rd),
    .be_o   (s1_be),
    .addr_o (s1_addr)
  );

  // stage 2 write commits this edge with live din; read of stage 1 sees it
  zbt_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i   (clk_i),
    .we_i    (en & s2_vld & ~s2_rd),
    .be_i    (s2_be),
    .waddr_i (s2_addr),
    .wdata_i (din_i),
    .raddr_i (s1_addr),
    .rdata_o (arr_rdata)
  );

  assign wr_hit  = s2_vld & ~s2_rd & (s2_addr == s1_addr);
  assign rd_word = wr_hit ? lane_merge(arr_rdata, din_i, s2_be) : arr_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld    <= 1'b0;
      s2_rd     <= 1'b0;
      s2_be     <= '0;
      s2_addr   <= '0;
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else if (en) begin
      s2_vld    <= s1_vld;
      s2_rd     <= s1_rd;
      s2_be     <= s1_be;
      s2_addr   <= s1_addr;
      dout_en_q <= s1_vld & s1_rd;
      if (s1_vld & s1_rd) dout_q <= rd_word;
    end
  end

  assign dout_o    = dout_q;
  assign dout_en_o = dout_en_q & ~oe_ni;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk import zbt_pkg::*; #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_en_ni,
  input logic          adv_ld_ni,
  input logic          sel,
  input logic          oe_ni,
  input logic          dout_en_o,
  input logic          dout_en_q,
  input word_t         dout_o,
  input logic          s1_vld,
  input logic          s1_rd,
  input logic [AW-1:0] s1_addr,
  input logic          s2_vld
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(dout_o) && $stable(dout_en_q) && $stable(s1_vld) && $stable(s2_vld)); // R3

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dout_en_o); // R7

  AST_DESEL_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !adv_ld_ni && !sel) |=> !s1_vld); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_ld_ni && !s1_vld) |=> !s1_vld); // R4

  AST_PIPE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_ni |=> s2_vld == $past(s1_vld)); // R5

  AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !(s1_vld && s1_rd)) |=> !dout_en_q); // R6

  AST_BURST_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_ld_ni && s1_vld) |=> s1_vld && (s1_rd == $past(s1_rd))); // R9

  AST_BURST_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && adv_ld_ni && s1_vld) |=> s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])); // R10
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_ni (clk_en_ni),
  .adv_ld_ni (adv_ld_ni),
  .sel       (sel),
  .oe_ni     (oe_ni),
  .dout_en_o (dout_en_o),
  .dout_en_q (dout_en_q),
  .dout_o    (dout_o),
  .s1_vld    (s1_vld),
  .s1_rd     (s1_rd),
  .s1_addr   (s1_addr),
  .s2_vld    (s2_vld)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [2:0] SEL   = 3'b010; // {ce1_ni, ce2_i, ce3_ni}
  localparam logic [2:0] DES_A = 3'b110;
  localparam logic [2:0] DES_B = 3'b000;
  localparam logic [2:0] DES_C = 3'b011;

  typedef logic [35:0] w_t;
  typedef struct packed {logic vld; logic rd; logic [AW-1:0] addr; logic [3:0] be;} op_t;
  typedef struct {logic en; w_t data; string tag;} exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clk_en_ni = 1'b1, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic adv_ld_ni = 1'b0, rw_i = 1'b0, lin_burst_i = 1'b1, oe_ni = 1'b0;
  logic [3:0] bw_ni = 4'hF;
  logic [AW-1:0] addr_i = '0;
  w_t din_i = '0, dout_o;
  logic dout_en_o;

  always #2 clk = ~clk;

  zbt_sram #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
    .ce3_ni(ce3_ni), .adv_ld_ni(adv_ld_ni), .rw_i(rw_i), .bw_ni(bw_ni), .addr_i(addr_i),
    .lin_burst_i(lin_burst_i), .oe_ni(oe_ni), .din_i(din_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  w_t   ref_mem [DEPTH];
  op_t  pend[$];
  exp_t sb[$];
  int   n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  logic b_act = 1'b0, b_rd = 1'b0;
  logic [AW-1:0] b_base = '0;
  int   b_cnt = 0;
  logic done = 1'b0;

  task automatic chk(input string tag, input w_t act, input w_t exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic w_t apply_mask(w_t o, w_t n, logic [3:0] be);
    w_t m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m[k*9 +: 9] = '1;
    return (o & ~m) | (n & m);
  endfunction

  // one cycle of stimulus; model updated on enabled edges only
  task automatic cyc(input logic stall, input logic ld_n, input logic [2:0] ce, input logic rd,
                     input logic [AW-1:0] a, input logic [3:0] bwn, input logic oe);
    op_t old, mid, nw;
    logic [1:0] lo;
    @(negedge clk);
    clk_en_ni = stall; adv_ld_ni = ld_n; {ce1_ni, ce2_i, ce3_ni} = ce;
    rw_i = rd; addr_i = a; bw_ni = bwn; oe_ni = oe;
    din_i = w_t'({$urandom(), $urandom()});
    if (!stall) begin
      old = pend[0]; mid = pend[1];
      if (old.vld && !old.rd) ref_mem[old.addr] = apply_mask(ref_mem[old.addr], din_i, old.be);
      sb.push_back('{en: mid.vld && mid.rd, data: (mid.vld && mid.rd) ? ref_mem[mid.addr] : '0, tag: cur_tag});
      if (!ld_n) begin
        if (ce == SEL) begin
          b_act = 1'b1; b_base = a; b_cnt = 0; b_rd = rd;
          nw = '{vld: 1'b1, rd: rd, addr: a, be: ~bwn};
        end else begin
          b_act = 1'b0; nw = '0;
        end
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) % 4;
        lo = lin_burst_i ? 2'(b_base[1:0] + 2'(b_cnt)) : (b_base[1:0] ^ 2'(b_cnt));
        nw = '{vld: 1'b1, rd: b_rd, addr: {b_base[AW-1:2], lo}, be: ~bwn};
      end else nw = '0;
      void'(pend.pop_front());
      pend.push_back(nw);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] bwn);
    cyc(1'b0, 1'b0, SEL, 1'b0, a, bwn, 1'b0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(1'b0, 1'b0, SEL, 1'b1, a, 4'hF, 1'b0);
  endtask
  task automatic adv(input logic r, input logic [3:0] bwn);
    cyc(1'b0, 1'b1, SEL, r, '0, bwn, 1'b0);
  endtask
  task automatic idle();
    cyc(1'b0, 1'b0, DES_A, 1'b1, '0, 4'hF, 1'b0);
  endtask

  // monitor: one scoreboard item per enabled edge, hold check on stalled edges
  initial begin
    logic en_s, rs;
    exp_t e;
    w_t pd;
    logic pe;
    pd = '0; pe = 1'b0;
    forever begin
      @(posedge clk);
      en_s = !clk_en_ni; rs = rst_ni;
      #1;
      if (rs && !done) begin
        if (en_s) begin
          if (sb.size() > 0) begin
            e = sb.pop_front();
            chk({e.tag, " bus enable"}, w_t'(dout_en_o), w_t'(e.en & !oe_ni));
            if (e.en && !oe_ni) chk({e.tag, " read data"}, dout_o, e.data);
          end
        end else begin
          chk("R3 stall holds data", dout_o, pd);
          chk("R3 stall holds enable", w_t'(dout_en_o), w_t'(pe));
        end
      end
      pd = dout_o; pe = dout_en_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    pend.push_back('0); pend.push_back('0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R12 reset enable", w_t'(dout_en_o), '0);

    // R1 R2: fill, then alternate reads and writes, then read back
    cur_tag = "R1";
    for (int i = 0; i < 8; i++) wr(AW'(16 + i*5), 4'h0);
    cur_tag = "R2";
    for (int i = 0; i < 8; i++) begin rd(AW'(16 + i*5)); wr(AW'(200 + i), 4'h0); end
    for (int i = 0; i < 8; i++) rd(AW'(200 + i));
    // R6: bus released for writes and deselects
    cur_tag = "R6";
    wr(AW'(250), 4'h0); idle(); rd(AW'(250)); idle(); idle();

    // R8: lane masks (lane k = bits 9k+8..9k)
    cur_tag = "R8";
    wr(AW'(300), 4'h0); wr(AW'(300), 4'b1010); wr(AW'(300), 4'b0111); wr(AW'(300), 4'hF); idle(); rd(AW'(300));

    // R11: read right behind a write to the same address
    cur_tag = "R11";
    wr(AW'(400), 4'h0); rd(AW'(400)); wr(AW'(401), 4'h0); wr(AW'(401), 4'b0110); rd(AW'(401)); rd(AW'(401));

    // R9 R10: linear write burst from misaligned base, interleaved read back
    cur_tag = "R9";
    lin_burst_i = 1'b1;
    wr(AW'(513), 4'h0); adv(1'b1, 4'h0); adv(1'b1, 4'b0011); adv(1'b0, 4'h0); adv(1'b1, 4'h0);
    idle();
    cur_tag = "R10";
    lin_burst_i = 1'b0;
    rd(AW'(514)); adv(1'b0, 4'h0); adv(1'b0, 4'h0); adv(1'b0, 4'h0); adv(1'b0, 4'h0); adv(1'b1, 4'h0);
    lin_burst_i = 1'b1;
    rd(AW'(515)); adv(1'b0, 4'h0); adv(1'b0, 4'h0); adv(1'b0, 4'h0);

    // R4 R5: deselect by each chip enable mid-burst; in-flight ops finish
    cur_tag = "R4";
    rd(AW'(512)); adv(1'b1, 4'hF); cyc(1'b0, 1'b0, DES_A, 1'b0, '0, 4'h0, 1'b0); adv(1'b0, 4'h0); adv(1'b1, 4'h0);
    cur_tag = "R5";
    wr(AW'(600), 4'h0); adv(1'b0, 4'h0); cyc(1'b0, 1'b0, DES_B, 1'b1, '0, 4'hF, 1'b0); adv(1'b1, 4'h0);
    rd(AW'(600)); rd(AW'(601)); cyc(1'b0, 1'b0, DES_C, 1'b1, '0, 4'hF, 1'b0); adv(1'b1, 4'hF); idle();

    // R3: stalls with garbage on every input, inside read and write pipelines
    cur_tag = "R3";
    wr(AW'(700), 4'h0);
    cyc(1'b1, 1'b0, SEL, 1'b0, AW'(700), 4'h0, 1'b0);
    cyc(1'b1, 1'b0, SEL, 1'b0, AW'(16), 4'h0, 1'b0);
    rd(AW'(700));
    cyc(1'b1, 1'b1, SEL, 1'b0, AW'(16), 4'h0, 1'b0);
    rd(AW'(16));
    cyc(1'b1, 1'b0, SEL, 1'b0, AW'(16), 4'h0, 1'b0);
    cyc(1'b1, 1'b0, SEL, 1'b0, AW'(16), 4'h0, 1'b0);
    idle(); rd(AW'(16)); idle(); idle();

    // R7: output enable removes drive during a read data cycle
    rd(AW'(21));
    cur_tag = "R7";
    cyc(1'b0, 1'b0, DES_A, 1'b1, '0, 4'hF, 1'b1);
    cur_tag = "R7 after release";
    rd(AW'(21)); idle(); idle();

    // R2: random mix over a few addresses
    cur_tag = "R2 random";
    for (int i = 0; i < 16; i++) wr(AW'(800 + i), 4'h0);
    for (int i = 0; i < 600; i++) begin
      logic s, l;
      logic [2:0] ce;
      s  = ($urandom % 10) == 0;
      l  = ($urandom % 4) == 0;
      ce = (($urandom % 8) == 0) ? DES_B : SEL;
      if (i % 150 == 0) lin_burst_i = ~lin_burst_i;
      cyc(s, l, ce, 1'($urandom), AW'(800 + ($urandom % 16)), 4'($urandom), 1'b0);
    end
    idle(); idle(); idle();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule